// File: doc/BRIEF.md
# Autoload Bus Master Sequencer

This block starts a bootstrap load on a shared parallel bus. A falling edge on its active-low load request wakes it from idle. It then raises a bus request and waits for a grant. Once granted, it makes a single direct write that places its own entry address, 0xFB00, into memory word 0x0005. The transfer uses a strobe/done handshake: the strobe stays low until the addressed slave answers with done.

After the write it drops off the bus and pulls its active-low level-1 interrupt line low. The line stays low until the processor answers. The processor answers by presenting the entry address 0xFB00 on the address lines with its address-valid qualifier high. That answer returns the sequencer to idle and sets a sticky completion flag. If done never comes back, a bounded wait ends the transfer and parks the block in an error state until master reset.

Top module: `autoload_master`

## Requirements
- R1: With the block idle, a high-to-low transition of `load_req_n` sampled at a rising clock edge starts the sequence, and `busy` is high from the next cycle.
- R2: After starting, `bus_req` is high. Until `bus_grant` is seen at a rising edge, `addr_oe` and `data_oe` stay low and `strb_n` and `wr_n` stay high.
- R3: In the cycle after the grant is sampled, the block drives `addr_out` = 0x0005 and `data_out` = 0xFB00 with `addr_oe` and `data_oe` high, and holds `wr_n` and `strb_n` low.
- R4: `strb_n` stays low while `done_n` is high. In the cycle after `done_n` is sampled low, `strb_n` and `wr_n` are high and `addr_oe`, `data_oe` and `bus_req` are low.
- R5: From the cycle after done is sampled, `irq_n` is low. It stays low until a cycle with `ack_valid` high and `ack_addr` = 0xFB00. An `ack_valid` with any other address has no effect.
- R6: In the cycle after a matching acknowledge, `irq_n` is high, `busy` is low and `complete` is high. `complete` then stays high until `rst_n` is asserted.
- R7: If `done_n` is still high after `TIMEOUT` (default 256) strobe cycles, the strobe is removed. `error` goes high and `busy` low, and `error` holds until `rst_n` is asserted. `strb_n` is low for exactly `TIMEOUT` cycles in that case.
- R8: A new falling edge of `load_req_n` while busy or in error is ignored. A request line still held low when the block returns to idle does not start a second sequence.
- R9: While `rst_n` is low, the sequencer returns to idle. All bus outputs go inactive and `busy`, `complete` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| load_req_n | input | 1 | Active-low autoload request, edge triggered |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| addr_out | output | 16 | Transfer address (0 when not driving) |
| addr_oe | output | 1 | Address output enable |
| data_out | output | 16 | Write data (0 when not driving) |
| data_oe | output | 1 | Data output enable |
| wr_n | output | 1 | Active-low write qualifier |
| strb_n | output | 1 | Active-low transfer strobe |
| done_n | input | 1 | Active-low transfer completion from the slave |
| irq_n | output | 1 | Active-low level-1 interrupt request |
| ack_valid | input | 1 | Processor address-valid qualifier |
| ack_addr | input | 16 | Address presented by the processor |
| busy | output | 1 | Sequence in progress |
| complete | output | 1 | Sticky: sequence finished with an acknowledge |
| error | output | 1 | Sticky: transfer timed out |

## Verification
The state that is hardest to reach from the ports is the timeout. The bench must hold a granted strobe for exactly `TIMEOUT` cycles without answering. It must then confirm that the strobe is still low on the last allowed cycle and released on the next one. A directed run withholds `done_n` and counts cycles at the negative edge to hit that boundary. The random passes vary the grant and done delays and inject acknowledges with wrong addresses and extra request edges during the interrupt wait. Together these show that only the exact entry address ends the wait.

// File: rtl/al_pkg.sv
package al_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_XFER = 3'd2,
    ST_IRQ  = 3'd3,
    ST_ERR  = 3'd4
  } al_state_t;

  // Acknowledge match: qualifier high and address equal to entry point.
  function automatic logic ack_match(input logic valid,
                                     input logic [15:0] addr,
                                     input logic [15:0] entry);
    return valid && (addr == entry);
  endfunction

  // Sequencer busy for every state that owns a phase of the load.
  function automatic logic state_busy(input al_state_t s);
    return (s == ST_REQ) || (s == ST_XFER) || (s == ST_IRQ);
  endfunction

endpackage

// File: rtl/al_fall_detect.sv
module al_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fell
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sig_n;
  end

  assign fell = prev_q && !sig_n;
endmodule

// File: rtl/al_timeout.sv
module al_timeout #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT) + 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = run && (cnt_q == LAST);
endmodule

// File: rtl/autoload_master.sv
module autoload_master #(
  parameter int          AW          = 16,
  parameter int          DW          = 16,
  parameter logic [15:0] TARGET_ADDR = 16'h0005,
  parameter logic [15:0] ENTRY_ADDR  = 16'hFB00,
  parameter int          TIMEOUT     = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req_n,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] addr_out,
  output logic          addr_oe,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          wr_n,
  output logic          strb_n,
  input  logic          done_n,
  output logic          irq_n,
  input  logic          ack_valid,
  input  logic [AW-1:0] ack_addr,
  output logic          busy,
  output logic          complete,
  output logic          error
);
  import al_pkg::*;

  al_state_t state_q, state_d;
  logic      start_evt;
  logic      tmo_hit;
  logic      ack_hit;
  logic      done_evt;
  logic      driving;
  logic      complete_q;

  al_fall_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_n (load_req_n),
    .fell  (start_evt)
  );

  al_timeout #(.LIMIT(TIMEOUT)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_XFER),
    .hit   (tmo_hit)
  );

  assign ack_hit  = (state_q == ST_IRQ) &&
                    ack_match(ack_valid, 16'(ack_addr), ENTRY_ADDR);
  assign done_evt = (state_q == ST_XFER) && !done_n;
  assign driving  = (state_q == ST_XFER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_evt) state_d = ST_REQ;
      ST_REQ:  if (bus_grant) state_d = ST_XFER;
      ST_XFER: begin
        if (done_evt)     state_d = ST_IRQ;
        else if (tmo_hit) state_d = ST_ERR;
      end
      ST_IRQ:  if (ack_hit) state_d = ST_IDLE;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      complete_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ack_hit) complete_q <= 1'b1;
    end
  end

  assign bus_req  = (state_q == ST_REQ) || driving;
  assign addr_oe  = driving;
  assign data_oe  = driving;
  assign addr_out = driving ? AW'(TARGET_ADDR) : '0;
  assign data_out = driving ? DW'(ENTRY_ADDR)  : '0;
  assign wr_n     = !driving;
  assign strb_n   = !driving;
  assign irq_n    = !(state_q == ST_IRQ);
  assign busy     = state_busy(state_q);
  assign complete = complete_q;
  assign error    = (state_q == ST_ERR);
endmodule

// File: rtl/al_checker.sv
module al_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_grant,
  input logic [15:0] addr_out,
  input logic        addr_oe,
  input logic [15:0] data_out,
  input logic        wr_n,
  input logic        strb_n,
  input logic        done_n,
  input logic        irq_n,
  input logic        complete,
  input logic        error,
  input logic        tmo_hit,
  input logic        ack_hit
);
  // R2: strobe only with the bus driven, and driving begins only after a grant
  a_r2_strobe_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_n |-> (addr_oe && bus_req));
  a_r2_grant_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_oe) |-> $past(bus_grant));

  // R3: fixed write values while driving
  a_r3_fixed_write: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oe |-> (addr_out == 16'h0005 && data_out == 16'hFB00 && !wr_n));

  // R4: strobe held until done, released after done
  a_r4_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_n && done_n && !tmo_hit) |=> !strb_n);
  a_r4_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_n && !done_n) |=> (strb_n && !irq_n));

  // R5: interrupt held until acknowledge; never overlaps the transfer
  a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !ack_hit) |=> !irq_n);
  a_r5_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!strb_n, !irq_n}));

  // R6: completion is sticky
  a_r6_complete_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> complete);

  // R7: error is sticky and keeps the bus quiet
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> (error && strb_n && !bus_req));
endmodule

bind autoload_master al_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_grant (bus_grant),
  .addr_out  (addr_out),
  .addr_oe   (addr_oe),
  .data_out  (data_out),
  .wr_n      (wr_n),
  .strb_n    (strb_n),
  .done_n    (done_n),
  .irq_n     (irq_n),
  .complete  (complete),
  .error     (error),
  .tmo_hit   (tmo_hit),
  .ack_hit   (ack_hit)
);

// File: tb/sim_autoload_master.sv
module sim_autoload_master;
  localparam time CLK_PERIOD = 10ns;
  localparam int  TMO        = 256;
  localparam int  WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_req_n = 1'b1;
  logic        bus_grant = 1'b0;
  logic        done_n = 1'b1;
  logic        ack_valid = 1'b0;
  logic [15:0] ack_addr = '0;
  logic        bus_req, addr_oe, data_oe, wr_n, strb_n, irq_n;
  logic        busy, complete, error;
  logic [15:0] addr_out, data_out;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autoload_master u0 (
    .clk(clk), .rst_n(rst_n), .load_req_n(load_req_n),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .addr_out(addr_out), .addr_oe(addr_oe),
    .data_out(data_out), .data_oe(data_oe),
    .wr_n(wr_n), .strb_n(strb_n), .done_n(done_n),
    .irq_n(irq_n), .ack_valid(ack_valid), .ack_addr(ack_addr),
    .busy(busy), .complete(complete), .error(error)
  );

  function automatic logic [15:0] exp_addr();  return 16'd5;      endfunction
  function automatic logic [15:0] exp_data();  return 16'd64256;  endfunction
  function automatic bit is_entry(input logic [15:0] a);
    return a == 16'hFB00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // step one clock; inputs change and outputs are sampled at negedge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic idle_checks(input string tag, input logic exp_complete);
    check({tag, " busy"}, busy, 0);
    check({tag, " bus_req"}, bus_req, 0);
    check({tag, " strb_n"}, strb_n, 1);
    check({tag, " irq_n"}, irq_n, 1);
    check({tag, " addr_oe"}, addr_oe, 0);
    check({tag, " complete"}, complete, exp_complete);
  endtask

  // start and reach the granted transfer
  task automatic start_and_grant(input int gdly);
    load_req_n = 1'b0;
    step();
    check("R1 busy after edge", busy, 1);
    check("R2 bus_req", bus_req, 1);
    for (int i = 0; i < gdly; i++) begin
      check("R2 no drive before grant", {addr_oe, data_oe, strb_n, wr_n}, 4'b0011);
      step();
    end
    bus_grant = 1'b1;
    step();
    bus_grant = 1'b0;
    check("R3 addr", addr_out, exp_addr());
    check("R3 data", data_out, exp_data());
    check("R3 strobe/write/oe", {strb_n, wr_n, addr_oe, data_oe}, 4'b0011);
  endtask

  task automatic full_pass(input int gdly, input int ddly, input int nbad);
    logic [15:0] a;
    start_and_grant(gdly);
    for (int i = 0; i < ddly; i++) begin
      step();
      check("R4 strobe held", strb_n, 0);
    end
    done_n = 1'b0;
    step();
    done_n = 1'b1;
    check("R4 released", {strb_n, wr_n, addr_oe, data_oe, bus_req}, 5'b11000);
    check("R5 irq asserted", irq_n, 0);
    // wrong-address acknowledges and a repeated request edge (R8)
    for (int i = 0; i < nbad; i++) begin
      do a = 16'($urandom); while (is_entry(a));
      ack_valid = 1'b1; ack_addr = a;
      load_req_n = (i % 2 == 0);
      step();
      check("R5 wrong ack ignored", irq_n, 0);
      check("R8 busy unchanged", {busy, bus_req}, 2'b10);
    end
    load_req_n = 1'b0;
    ack_valid = 1'b0; ack_addr = 16'hFB00;
    step();
    check("R5 entry addr without valid ignored", irq_n, 0);
    ack_valid = 1'b1;
    step();
    ack_valid = 1'b0;
    check("R6 irq released", irq_n, 1);
    check("R6 idle", busy, 0);
    check("R6 complete", complete, 1);
    step(3);
    check("R8 held request no restart", {busy, bus_req}, 2'b00);
    load_req_n = 1'b1;
    step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(3);
    idle_checks("R9 reset", 0);
    check("R9 error", error, 0);
    rst_n = 1'b1;
    step(2);

    full_pass(0, 0, 0);
    full_pass(3, 5, 4);
    for (int k = 0; k < 12; k++)
      full_pass(int'($urandom_range(0, 6)), int'($urandom_range(0, 40)),
                int'($urandom_range(0, 5)));
    check("R6 complete still set", complete, 1);

    // timeout boundary
    start_and_grant(2);
    step(TMO - 1);
    check("R7 strobe on last allowed cycle", strb_n, 0);
    check("R7 no error yet", error, 0);
    step();
    check("R7 strobe removed", strb_n, 1);
    check("R7 error", error, 1);
    check("R7 not busy", busy, 0);
    load_req_n = 1'b1; step(); load_req_n = 1'b0; step(2);
    check("R8 ignored in error", {busy, bus_req, error}, 3'b001);
    done_n = 1'b0; step(); done_n = 1'b1;
    check("R7 error holds", error, 1);

    rst_n = 1'b0; load_req_n = 1'b1;
    step(2);
    idle_checks("R9 reset clears", 0);
    check("R9 error cleared", error, 0);
    rst_n = 1'b1;
    step(2);
    full_pass(1, 2, 1);
    summary();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule